// File: doc/BRIEF.md
# Register Busy-Bit Issue Interlock

This block guards the decode stage of an in-order pipeline whose results come back over several writeback paths that may finish out of order, for example a short arithmetic pipe next to a longer load pipe. It keeps one busy flag per architectural register. A flag is raised when an instruction that writes the register leaves decode, and it is dropped when any writeback path writes that register back.

Every cycle the block looks at the operands of the instruction that sits in decode. It raises `stall` when any valid source, or the valid destination, names a register whose flag is up. The destination is checked as well as the sources, so write-after-write and write-after-read orderings are kept without any bypass network. The only cost is that such hazards wait in decode longer than strictly needed. Register 0 is a constant-zero register and never blocks.

Top module: `regbusy_interlock`

## Requirements
- R1: After a synchronous active-high reset every busy flag is clear, so an operand naming any register causes no stall.
- R2: A valid source operand that names a busy register, with no writeback to that register in the same cycle, drives `stall` high.
- R3: A valid destination operand that names a busy register, with no writeback to that register in the same cycle, drives `stall` high. An instruction never leaves decode toward a busy destination.
- R4: A register's flag becomes busy on the next clock edge only when `issue_take` is high, `stall` is low, `dec_dst_vld` is high and `dec_dst_idx` names that register. Without such an issue a flag does not change, except when a writeback clears it.
- R5: A writeback port with its valid bit high clears the named register's flag on the next edge. The two ports can clear two different registers in the same cycle.
- R6: A register that is being written back in the current cycle counts as free for the stall decision in that same cycle.
- R7: If an issue sets a flag and a writeback clears the same flag in the same cycle, the flag ends up busy.
- R8: Register index 0 is never busy. An issue to destination 0 marks nothing, and an operand naming 0 never stalls.
- R9: Operands whose valid bit is low never cause a stall, whatever their index.
- R10: `stall` is combinational. It follows the current flags and decode operands within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_src_vld | input | NUM_SRC (2) | Valid bit per decode source operand |
| dec_src_idx | input | NUM_SRC*RW (10) | Source register indices. Source k occupies bits [k*RW +: RW] |
| dec_dst_vld | input | 1 | Decode instruction writes a register |
| dec_dst_idx | input | RW (5) | Destination register index |
| issue_take | input | 1 | Downstream accepts the decode instruction this cycle. It counts only when `stall` is low |
| wb_vld | input | NUM_WB (2) | Valid bit per writeback port |
| wb_idx | input | NUM_WB*RW (10) | Written-back register indices. Port k occupies bits [k*RW +: RW] |
| stall | output | 1 | Hold the decode instruction |

## Verification
Two things can fall into the same cycle. A writeback can clear a flag while decode is checking it, and an issue can set a flag while a writeback clears that same flag. Directed cycles provoke both. A busy register is named as a source while a writeback port names it, and `stall` must read low (R6). A free register is issued as a destination while a writeback port names it, and a later probe through a source operand must show it busy (R7). A long random run then draws indices from a small range so these collisions happen often. A behavioural model in the bench judges `stall` on every cycle.

// File: rtl/regbusy_pkg.sv
package regbusy_pkg;

    parameter int unsigned RB_NUM_REGS = 32;
    parameter int unsigned RB_NUM_SRC  = 2;
    parameter int unsigned RB_NUM_WB   = 2;

    // Index width for a register file of n entries (at least one bit).
    function automatic int unsigned rb_idx_w(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/regbusy_wb_mask.sv
module regbusy_wb_mask
    import regbusy_pkg::*;
#(
    parameter int unsigned NUM_REGS = RB_NUM_REGS,
    parameter int unsigned NUM_WB   = RB_NUM_WB,
    localparam int unsigned RW      = rb_idx_w(NUM_REGS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_WB-1:0]      wb_vld,
    input  logic [NUM_WB*RW-1:0]   wb_idx,
    output logic [NUM_REGS-1:0]    clr_mask
);

    // One decoded clear vector per port, then ORed together.
    logic [NUM_REGS-1:0] port_mask [NUM_WB];

    for (genvar p = 0; p < NUM_WB; p++) begin : g_port
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            if (r == 0) begin : g_zero
                assign port_mask[p][r] = 1'b0;
            end else begin : g_live
                assign port_mask[p][r] = wb_vld[p] && (wb_idx[p*RW +: RW] == RW'(r));
            end
        end
    end

    always_comb begin
        clr_mask = '0;
        for (int p = 0; p < NUM_WB; p++) begin
            clr_mask = clr_mask | port_mask[p];
        end
    end

    // R5: never more registers cleared than there are ports
    p_clear_count_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(clr_mask) <= NUM_WB);

endmodule

// File: rtl/regbusy_hazard.sv
module regbusy_hazard
    import regbusy_pkg::*;
#(
    parameter int unsigned NUM_REGS = RB_NUM_REGS,
    parameter int unsigned NUM_SRC  = RB_NUM_SRC,
    localparam int unsigned RW      = rb_idx_w(NUM_REGS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_REGS-1:0]    busy_q,
    input  logic [NUM_REGS-1:0]    clr_mask,
    input  logic [NUM_SRC-1:0]     src_vld,
    input  logic [NUM_SRC*RW-1:0]  src_idx,
    input  logic                   dst_vld,
    input  logic [RW-1:0]          dst_idx,
    output logic                   stall
);

    // A register blocks only if busy and not being written back now.
    logic [NUM_REGS-1:0] blocking;
    logic [NUM_SRC-1:0]  src_hit;
    logic                dst_hit;

    always_comb begin
        blocking    = busy_q & ~clr_mask;
        blocking[0] = 1'b0;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign src_hit[s] = src_vld[s] && blocking[src_idx[s*RW +: RW]];
    end

    assign dst_hit = dst_vld && blocking[dst_idx];
    assign stall   = (|src_hit) || dst_hit;

    // R2: a valid source on a busy, not-retiring register holds decode
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
        p_src_busy_holds_r2: assert property (@(posedge clk) disable iff (rst)
            (src_vld[s] && (src_idx[s*RW +: RW] != '0)
             && busy_q[src_idx[s*RW +: RW]] && !clr_mask[src_idx[s*RW +: RW]])
            |-> stall);
    end

    // R9: with nothing valid in decode there is never a stall
    p_invalid_free_r9: assert property (@(posedge clk) disable iff (rst)
        (!(|src_vld) && !dst_vld) |-> !stall);

endmodule

// File: rtl/regbusy_flags.sv
module regbusy_flags
    import regbusy_pkg::*;
#(
    parameter int unsigned NUM_REGS = RB_NUM_REGS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REGS-1:0] set_mask,
    input  logic [NUM_REGS-1:0] clr_mask,
    output logic [NUM_REGS-1:0] busy_q
);

    // Clear first, then set: a collision leaves the flag busy.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
        end else begin
            busy_q <= (busy_q & ~clr_mask) | set_mask;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
        // R4 / R7: an issue always lands, even against a writeback
        p_set_lands_r4: assert property (@(posedge clk) disable iff (rst)
            set_mask[g] |=> busy_q[g]);
        // R5: a lone writeback frees the register
        p_clear_lands_r5: assert property (@(posedge clk) disable iff (rst)
            (clr_mask[g] && !set_mask[g]) |=> !busy_q[g]);
        // R4: no event, no change
        p_hold_quiet_r4: assert property (@(posedge clk) disable iff (rst)
            (!clr_mask[g] && !set_mask[g]) |=> $stable(busy_q[g]));
    end

endmodule

// File: rtl/regbusy_interlock.sv
module regbusy_interlock
    import regbusy_pkg::*;
#(
    parameter int unsigned NUM_REGS = RB_NUM_REGS,
    parameter int unsigned NUM_SRC  = RB_NUM_SRC,
    parameter int unsigned NUM_WB   = RB_NUM_WB,
    localparam int unsigned RW      = rb_idx_w(NUM_REGS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_SRC-1:0]     dec_src_vld,
    input  logic [NUM_SRC*RW-1:0]  dec_src_idx,
    input  logic                   dec_dst_vld,
    input  logic [RW-1:0]          dec_dst_idx,
    input  logic                   issue_take,
    input  logic [NUM_WB-1:0]      wb_vld,
    input  logic [NUM_WB*RW-1:0]   wb_idx,
    output logic                   stall
);

    logic [NUM_REGS-1:0] busy_q;
    logic [NUM_REGS-1:0] clr_mask;
    logic [NUM_REGS-1:0] set_mask;
    logic                fire;

    regbusy_wb_mask #(.NUM_REGS(NUM_REGS), .NUM_WB(NUM_WB)) u_wb (
        .clk      (clk),
        .rst      (rst),
        .wb_vld   (wb_vld),
        .wb_idx   (wb_idx),
        .clr_mask (clr_mask)
    );

    regbusy_hazard #(.NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC)) u_hz (
        .clk      (clk),
        .rst      (rst),
        .busy_q   (busy_q),
        .clr_mask (clr_mask),
        .src_vld  (dec_src_vld),
        .src_idx  (dec_src_idx),
        .dst_vld  (dec_dst_vld),
        .dst_idx  (dec_dst_idx),
        .stall    (stall)
    );

    // Issue happens only when accepted and not held.
    assign fire = issue_take && !stall && dec_dst_vld;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_set
        if (r == 0) begin : g_zero
            assign set_mask[r] = 1'b0;
        end else begin : g_live
            assign set_mask[r] = fire && (dec_dst_idx == RW'(r));
        end
    end

    regbusy_flags #(.NUM_REGS(NUM_REGS)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .busy_q   (busy_q)
    );

    // R8: the constant register is never marked
    p_reg0_free_r8: assert property (@(posedge clk) disable iff (rst)
        !busy_q[0]);

    // R3: an issuing instruction never targets a blocking register
    p_issue_dst_free_r3: assert property (@(posedge clk) disable iff (rst)
        (issue_take && !stall && dec_dst_vld && dec_dst_idx != '0)
        |-> (!busy_q[dec_dst_idx] || clr_mask[dec_dst_idx]));

    // R1: flags start empty after reset
    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (busy_q == '0));

endmodule

// File: tb/regbusy_interlock_test.sv
`timescale 1ns/1ps
module regbusy_interlock_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] sv;
    logic [4:0] s0, s1;
    logic       dv;
    logic [4:0] d;
    logic       take;
    logic [1:0] wv;
    logic [4:0] w0, w1;
    logic       stall;

    int checks = 0;
    int bad    = 0;
    bit ref_busy [32];

    always #2.5 clk = ~clk;

    regbusy_interlock uut (
        .clk         (clk),
        .rst         (rst),
        .dec_src_vld (sv),
        .dec_src_idx ({s1, s0}),
        .dec_dst_vld (dv),
        .dec_dst_idx (d),
        .issue_take  (take),
        .wb_vld      (wv),
        .wb_idx      ({w1, w0}),
        .stall       (stall)
    );

    function automatic bit reg_free(input logic [4:0] r);
        if (r == 5'd0) return 1'b1;
        if (wv[0] && w0 == r) return 1'b1;
        if (wv[1] && w1 == r) return 1'b1;
        return !ref_busy[r];
    endfunction

    function automatic bit src_block();
        return (sv[0] && !reg_free(s0)) || (sv[1] && !reg_free(s1));
    endfunction

    function automatic bit exp_stall();
        return src_block() || (dv && !reg_free(d));
    endfunction

    task automatic idle();
        sv = '0; s0 = '0; s1 = '0; dv = 1'b0; d = '0;
        take = 1'b0; wv = '0; w0 = '0; w1 = '0;
    endtask

    task automatic check(input string tag, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: stall=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: compare against the model, advance the model, return at negedge.
    task automatic cyc(input string tag);
        bit e;
        #1;
        e = exp_stall();
        check(tag, stall, e);
        @(posedge clk);
        if (wv[0] && w0 != 0) ref_busy[w0] = 1'b0;
        if (wv[1] && w1 != 0) ref_busy[w1] = 1'b0;
        if (take && !e && dv && d != 0) ref_busy[d] = 1'b1;
        @(negedge clk);
    endtask

    // Observe one flag through a source operand.
    task automatic probe(input logic [4:0] r, input bit exp_busy, input string tag);
        idle();
        sv = 2'b01; s0 = r;
        #1;
        check(tag, stall, exp_busy);
        cyc(tag);
    endtask

    task automatic issue(input logic [4:0] r, input string tag);
        idle();
        dv = 1'b1; d = r; take = 1'b1;
        cyc(tag);
    endtask

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog: run did not end, actual running expected done");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        foreach (ref_busy[i]) ref_busy[i] = 1'b0;

        // R1: everything free after reset
        for (int r = 0; r < 32; r++) probe(5'(r), 1'b0, "R1");

        // R4: issue sets the destination flag
        issue(5'd5, "R4");
        probe(5'd5, 1'b1, "R4");

        // R2: source on busy register stalls
        idle(); sv = 2'b10; s1 = 5'd5; #1; check("R2", stall, 1'b1); cyc("R2");

        // R3: destination on busy register stalls and does not re-issue
        idle(); dv = 1'b1; d = 5'd5; take = 1'b1; #1; check("R3", stall, 1'b1); cyc("R3");

        // R4: no issue without take
        idle(); dv = 1'b1; d = 5'd7; cyc("R4");
        probe(5'd7, 1'b0, "R4");

        // R10: stall follows operands within the cycle
        idle(); #1; check("R10", stall, 1'b0);
        sv = 2'b01; s0 = 5'd5; #0.5; check("R10", stall, 1'b1);
        cyc("R10");

        // R9: invalid operands naming busy registers do not stall
        idle(); s0 = 5'd5; s1 = 5'd5; d = 5'd5; #1; check("R9", stall, 1'b0); cyc("R9");

        // R6: writeback same cycle as check counts free
        idle(); sv = 2'b01; s0 = 5'd5; wv = 2'b10; w1 = 5'd5;
        #1; check("R6", stall, 1'b0); cyc("R6");
        probe(5'd5, 1'b0, "R6");

        // R7: set and clear collide, set wins
        idle(); dv = 1'b1; d = 5'd12; take = 1'b1; wv = 2'b01; w0 = 5'd12;
        #1; check("R7", stall, 1'b0); cyc("R7");
        probe(5'd12, 1'b1, "R7");

        // R5: two ports clear two registers at once
        issue(5'd9, "R5");
        probe(5'd9, 1'b1, "R5");
        idle(); wv = 2'b11; w0 = 5'd9; w1 = 5'd12; cyc("R5");
        probe(5'd9, 1'b0, "R5");
        probe(5'd12, 1'b0, "R5");

        // R8: destination 0 never marks, source 0 never stalls
        issue(5'd0, "R8");
        probe(5'd0, 1'b0, "R8");
        idle(); dv = 1'b1; d = 5'd0; sv = 2'b11; #1; check("R8", stall, 1'b0); cyc("R8");

        // Random mix over a narrow index range, compared every cycle
        for (int n = 0; n < 3000; n++) begin
            sv   = 2'($urandom_range(0, 3));
            s0   = 5'($urandom_range(0, 7));
            s1   = 5'($urandom_range(0, 7));
            dv   = 1'($urandom_range(0, 1));
            d    = 5'($urandom_range(0, 7));
            take = ($urandom_range(0, 3) != 0);
            wv   = 2'($urandom_range(0, 3));
            w0   = 5'($urandom_range(0, 7));
            w1   = 5'($urandom_range(0, 7));
            if (src_block()) cyc("R2");
            else if (exp_stall()) cyc("R3");
            else cyc("R6");
        end

        // Final sweep of all flags against the model (R4, R5)
        for (int r = 1; r < 32; r++) probe(5'(r), ref_busy[r], "R5");

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule